// File: doc/BRIEF.md
# Block Address Translation Matcher

This block translates a 32-bit effective address through two small banks of block-mapping entries. One bank serves instruction fetches and the other serves data accesses. Each bank holds eight entries. An entry names an effective region through an index and a mask. It supplies a real page base and a 2-bit protection code. Two enable bits control whether the entry is active in user mode and whether it is active in supervisor mode.

Software loads an entry in a single cycle through a write port. A lookup presents the address, the bank select, the privilege mode and the segment's virtual segment identifier. One clock later the block reports hit or miss, the translated real address, the access flags and the virtual page number. All entries of the chosen bank are compared at once. The lowest-numbered entry that is enabled for the current mode, matches the address and grants read/write access is the one used. Entries that grant no access or read-only access are passed over, so the search continues past them. A miss lets the caller fall back to its page-table walk.

Top module: `bat_xlate`

## Requirements
- R1: While reset is asserted and on the first cycle after it, rsp_valid is 0. After reset every entry is disabled in both modes, so every lookup misses.
- R2: lk_data=1 searches only the data bank and lk_data=0 searches only the instruction bank. wr_data_bank uses the same encoding.
- R3: With lk_user=1 an entry takes part only if its user-enable bit is set. With lk_user=0 it takes part only if its supervisor-enable bit is set.
- R4: An entry matches when (lk_ea AND mask) equals the entry's effective index.
- R5: On a hit, rsp_ra equals the entry's real base ORed with (lk_ea AND NOT mask).
- R6: The protection code decodes as follows: 0 means no access, 1 means read-only, and 2 or 3 mean read/write. A matching entry with code 0 or 1 is skipped and the search goes on to higher indices.
- R7: When several usable entries match, the one with the lowest index supplies the result.
- R8: On a hit, rsp_rd, rsp_wr and rsp_ex are all 1.
- R9: For every response, rsp_vpn equals {lk_vsid, lk_ea[27:12]} of the request.
- R10: A lookup accepted on one rising edge is answered at the next rising edge. rsp_valid mirrors lk_valid delayed by one cycle.
- R11: A lookup issued in the same cycle as a write sees the table as it stood before that write. The write takes effect for lookups issued from the next cycle on.
- R12: On a miss (rsp_valid=1, rsp_hit=0), rsp_ra is 0 and all three access flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write one entry this cycle |
| wr_data_bank | input | 1 | 1 = data bank, 0 = instruction bank |
| wr_idx | input | 3 | Entry index to write |
| wr_epi | input | 32 | Effective index of the region |
| wr_mask | input | 32 | Address mask of the region |
| wr_rpn | input | 32 | Real base of the region |
| wr_prot | input | 2 | Protection code |
| wr_user_ok | input | 1 | Entry enabled in user mode |
| wr_sup_ok | input | 1 | Entry enabled in supervisor mode |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address |
| lk_data | input | 1 | 1 = data access, 0 = instruction fetch |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| lk_vsid | input | 24 | Virtual segment identifier for the address |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | A usable entry matched |
| rsp_ra | output | 32 | Real address |
| rsp_rd | output | 1 | Read allowed |
| rsp_wr | output | 1 | Write allowed |
| rsp_ex | output | 1 | Execute allowed |
| rsp_vpn | output | 40 | Virtual page number |

## Verification
Entry loading and translation can happen in the same cycle, and they can even target the entry that the lookup will select. The bench holds one data entry mapped to a known real base. In a single cycle it drives a rewrite of that entry to a new base and a lookup that matches it. The first response must carry the old base. A second lookup issued right afterwards must carry the new base. Beyond that case, many randomly built tables with deliberately overlapping regions are swept. This exercises skipping and priority while writes and lookups alternate.

// File: rtl/bat_pkg.sv
package bat_pkg;

    localparam int BAT_AW     = 32;
    localparam int BAT_VSID_W = 24;
    localparam int BAT_PG_LSB = 12;
    localparam int BAT_SEG_MSB = 27;
    localparam int BAT_VPN_W  = BAT_VSID_W + (BAT_SEG_MSB - BAT_PG_LSB + 1);

    typedef struct packed {
        logic              user_ok;
        logic              sup_ok;
        logic [1:0]        prot;
        logic [BAT_AW-1:0] epi;
        logic [BAT_AW-1:0] mask;
        logic [BAT_AW-1:0] rpn;
    } bat_entry_t;

    typedef struct packed {
        logic                 valid;
        logic                 hit;
        logic [BAT_AW-1:0]    ra;
        logic                 rd;
        logic                 wr;
        logic                 ex;
        logic [BAT_VPN_W-1:0] vpn;
    } bat_rsp_t;

endpackage

// File: rtl/bat_bank.sv
module bat_bank
    import bat_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [IW-1:0]          widx,
    input  bat_entry_t             wdata,
    output bat_entry_t [N_ENT-1:0] ents_o
);

    bat_entry_t [N_ENT-1:0] ents_d, ents_q;

    always_comb begin
        ents_d = ents_q;
        if (we) begin
            ents_d[widx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ents_q <= '0;
        end else begin
            ents_q <= ents_d;
        end
    end

    assign ents_o = ents_q;

endmodule

// File: rtl/bat_pick.sv
module bat_pick
    import bat_pkg::*;
#(
    parameter int N_ENT = 8
) (
    input  bat_entry_t [N_ENT-1:0] ents,
    input  logic [BAT_AW-1:0]      ea,
    input  logic                   user,
    output logic                   hit,
    output logic [BAT_AW-1:0]      ra
);

    logic [N_ENT-1:0] usable;

    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        logic enabled;
        logic matched;
        logic rw_ok;
        assign enabled = user ? ents[i].user_ok : ents[i].sup_ok;
        assign matched = ((ea & ents[i].mask) == ents[i].epi);
        assign rw_ok   = ents[i].prot[1];
        assign usable[i] = enabled && matched && rw_ok;
    end

    always_comb begin
        hit = 1'b0;
        ra  = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (!hit && usable[i]) begin
                hit = 1'b1;
                ra  = ents[i].rpn | (ea & ~ents[i].mask);
            end
        end
    end

endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
    import bat_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_data_bank,
    input  logic [IW-1:0]         wr_idx,
    input  logic [BAT_AW-1:0]     wr_epi,
    input  logic [BAT_AW-1:0]     wr_mask,
    input  logic [BAT_AW-1:0]     wr_rpn,
    input  logic [1:0]            wr_prot,
    input  logic                  wr_user_ok,
    input  logic                  wr_sup_ok,
    input  logic                  lk_valid,
    input  logic [BAT_AW-1:0]     lk_ea,
    input  logic                  lk_data,
    input  logic                  lk_user,
    input  logic [BAT_VSID_W-1:0] lk_vsid,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic [BAT_AW-1:0]     rsp_ra,
    output logic                  rsp_rd,
    output logic                  rsp_wr,
    output logic                  rsp_ex,
    output logic [BAT_VPN_W-1:0]  rsp_vpn
);

    localparam int N_BANK = 2;

    bat_entry_t             wr_ent;
    bat_entry_t [N_ENT-1:0] bank_ents [N_BANK];
    bat_entry_t [N_ENT-1:0] sel_ents;
    logic                   sel_hit;
    logic [BAT_AW-1:0]      sel_ra;
    bat_rsp_t               rsp_d, rsp_q;

    always_comb begin
        wr_ent.user_ok = wr_user_ok;
        wr_ent.sup_ok  = wr_sup_ok;
        wr_ent.prot    = wr_prot;
        wr_ent.epi     = wr_epi;
        wr_ent.mask    = wr_mask;
        wr_ent.rpn     = wr_rpn;
    end

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        bat_bank #(.N_ENT(N_ENT)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (wr_en && (wr_data_bank == 1'(b))),
            .widx   (wr_idx),
            .wdata  (wr_ent),
            .ents_o (bank_ents[b])
        );
    end

    assign sel_ents = lk_data ? bank_ents[1] : bank_ents[0];

    bat_pick #(.N_ENT(N_ENT)) u_pick (
        .ents (sel_ents),
        .ea   (lk_ea),
        .user (lk_user),
        .hit  (sel_hit),
        .ra   (sel_ra)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = lk_valid;
        rsp_d.hit   = lk_valid && sel_hit;
        rsp_d.ra    = rsp_d.hit ? sel_ra : '0;
        rsp_d.rd    = rsp_d.hit;
        rsp_d.wr    = rsp_d.hit;
        rsp_d.ex    = rsp_d.hit;
        rsp_d.vpn   = {lk_vsid, lk_ea[BAT_SEG_MSB:BAT_PG_LSB]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_ra    = rsp_q.ra;
    assign rsp_rd    = rsp_q.rd;
    assign rsp_wr    = rsp_q.wr;
    assign rsp_ex    = rsp_q.ex;
    assign rsp_vpn   = rsp_q.vpn;

endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk
    import bat_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic                  wr_data_bank,
    input logic [IW-1:0]         wr_idx,
    input logic [BAT_AW-1:0]     wr_epi,
    input logic [BAT_AW-1:0]     wr_mask,
    input logic [BAT_AW-1:0]     wr_rpn,
    input logic [1:0]            wr_prot,
    input logic                  wr_user_ok,
    input logic                  wr_sup_ok,
    input logic                  lk_valid,
    input logic [BAT_AW-1:0]     lk_ea,
    input logic                  lk_data,
    input logic                  lk_user,
    input logic [BAT_VSID_W-1:0] lk_vsid,
    input logic                  rsp_valid,
    input logic                  rsp_hit,
    input logic [BAT_AW-1:0]     rsp_ra,
    input logic                  rsp_rd,
    input logic                  rsp_wr,
    input logic                  rsp_ex,
    input logic [BAT_VPN_W-1:0]  rsp_vpn
);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !rsp_valid); // R1

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_valid && !rsp_hit)); // R10

    AST_HIT_PERMS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_valid && rsp_rd && rsp_wr && rsp_ex)); // R8

    AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_ra == '0 && !rsp_rd && !rsp_wr && !rsp_ex)); // R12

    AST_VPN_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (rsp_vpn == {$past(lk_vsid), $past(lk_ea[BAT_SEG_MSB:BAT_PG_LSB])})); // R9

endmodule

bind bat_xlate bat_xlate_chk #(.N_ENT(N_ENT)) u_chk (.*);

// File: tb/sim_bat_xlate.sv
`timescale 1ns/1ps
module sim_bat_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_data_bank = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_epi = '0, wr_mask = '0, wr_rpn = '0;
    logic [1:0]  wr_prot = '0;
    logic        wr_user_ok = 1'b0, wr_sup_ok = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_ea = '0;
    logic        lk_data = 1'b0, lk_user = 1'b0;
    logic [23:0] lk_vsid = '0;
    logic        rsp_valid, rsp_hit, rsp_rd, rsp_wr, rsp_ex;
    logic [31:0] rsp_ra;
    logic [39:0] rsp_vpn;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] m_epi  [2][8];
    logic [31:0] m_mask [2][8];
    logic [31:0] m_rpn  [2][8];
    logic [1:0]  m_prot [2][8];
    logic        m_uok  [2][8];
    logic        m_sok  [2][8];

    always #10 clk = ~clk;

    bat_xlate u0 (.*);

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model(input int b, input bit user, input logic [31:0] ea,
                         output bit hit, output logic [31:0] ra);
        hit = 0;
        ra  = '0;
        for (int i = 0; i < 8; i++) begin
            if (!hit && (user ? m_uok[b][i] : m_sok[b][i]) &&
                ((ea & m_mask[b][i]) == m_epi[b][i]) && (m_prot[b][i] >= 2)) begin
                hit = 1;
                ra  = m_rpn[b][i] | (ea & ~m_mask[b][i]);
            end
        end
    endtask

    task automatic put_write(input bit b, input int idx, input logic [31:0] epi, input logic [31:0] msk,
                             input logic [31:0] rpn, input logic [1:0] prot, input bit uok, input bit sok);
        wr_en = 1; wr_data_bank = b; wr_idx = 3'(idx);
        wr_epi = epi; wr_mask = msk; wr_rpn = rpn; wr_prot = prot;
        wr_user_ok = uok; wr_sup_ok = sok;
    endtask

    task automatic note_write(input bit b, input int idx, input logic [31:0] epi, input logic [31:0] msk,
                              input logic [31:0] rpn, input logic [1:0] prot, input bit uok, input bit sok);
        m_epi[b][idx] = epi; m_mask[b][idx] = msk; m_rpn[b][idx] = rpn;
        m_prot[b][idx] = prot; m_uok[b][idx] = uok; m_sok[b][idx] = sok;
    endtask

    task automatic write_ent(input bit b, input int idx, input logic [31:0] epi, input logic [31:0] msk,
                             input logic [31:0] rpn, input logic [1:0] prot, input bit uok, input bit sok);
        @(negedge clk);
        put_write(b, idx, epi, msk, rpn, prot, uok, sok);
        @(negedge clk);
        wr_en = 0;
        note_write(b, idx, epi, msk, rpn, prot, uok, sok);
    endtask

    task automatic judge(input string tag, input bit ehit, input logic [31:0] era,
                         input logic [23:0] vsid, input logic [31:0] ea);
        logic [39:0] evpn;
        evpn = {vsid, ea[27:12]};
        check(rsp_valid == 1'b1, {tag, " valid"}, 64'(rsp_valid), 64'(1));
        check(rsp_hit == ehit, {tag, " hit"}, 64'(rsp_hit), 64'(ehit));
        check(rsp_ra == era, {tag, " ra"}, 64'(rsp_ra), 64'(era));
        check({rsp_rd, rsp_wr, rsp_ex} == {3{ehit}}, {tag, " R8 flags"},
              64'({rsp_rd, rsp_wr, rsp_ex}), 64'({3{ehit}}));
        check(rsp_vpn == evpn, {tag, " R9 vpn"}, 64'(rsp_vpn), 64'(evpn));
    endtask

    task automatic lookup(input string tag, input bit b, input bit user,
                          input logic [31:0] ea, input logic [23:0] vsid);
        bit ehit;
        logic [31:0] era;
        model(int'(b), user, ea, ehit, era);
        @(negedge clk);
        lk_valid = 1; lk_data = b; lk_user = user; lk_ea = ea; lk_vsid = vsid;
        @(negedge clk);
        lk_valid = 0;
        judge(tag, ehit, era, vsid, ea);
    endtask

    task automatic expect_ra(input string tag, input bit b, input bit user,
                             input logic [31:0] ea, input bit ehit, input logic [31:0] era);
        @(negedge clk);
        lk_valid = 1; lk_data = b; lk_user = user; lk_ea = ea; lk_vsid = 24'h00ABCD;
        @(negedge clk);
        lk_valid = 0;
        judge(tag, ehit, era, 24'h00ABCD, ea);
    endtask

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 8; i++)
                note_write(b[0], i, '0, '0, '0, 2'd0, 1'b0, 1'b0);

        // R1: reset state
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R1 valid in reset", 64'(rsp_valid), 64'(0));
        rst_n = 1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1 valid after reset", 64'(rsp_valid), 64'(0));
        for (int c = 0; c < 4; c++)
            expect_ra("R1 empty table", c[0], c[1], 32'h0000_0000, 1'b0, 32'h0);

        // R4 R5 R3 R2: one user-only data entry
        write_ent(1, 0, 32'h1000_0000, 32'hF000_0000, 32'h8000_0000, 2'd2, 1, 0);
        expect_ra("R4 R5 data user hit", 1, 1, 32'h1234_5678, 1, 32'h8234_5678);
        expect_ra("R3 sup disabled", 1, 0, 32'h1234_5678, 0, 32'h0);
        expect_ra("R2 instr bank empty", 0, 1, 32'h1234_5678, 0, 32'h0);
        expect_ra("R4 no match", 1, 1, 32'h2234_5678, 0, 32'h0);

        write_ent(0, 0, 32'h1000_0000, 32'hF000_0000, 32'h4000_0000, 2'd3, 0, 1);
        expect_ra("R2 R3 instr sup hit", 0, 0, 32'h1234_5678, 1, 32'h4234_5678);
        expect_ra("R2 data sup still off", 1, 0, 32'h1234_5678, 0, 32'h0);
        expect_ra("R3 instr user off", 0, 1, 32'h1234_5678, 0, 32'h0);

        // R6 R7: skip read-only and no-access entries, lowest usable wins
        write_ent(1, 1, 32'h3000_0000, 32'hF000_0000, 32'h9000_0000, 2'd1, 1, 1);
        write_ent(1, 2, 32'h3000_0000, 32'hF000_0000, 32'hA000_0000, 2'd0, 1, 1);
        expect_ra("R6 only ro/none", 1, 1, 32'h3000_0ABC, 0, 32'h0);
        write_ent(1, 3, 32'h3000_0000, 32'hF000_0000, 32'hB000_0000, 2'd3, 1, 1);
        write_ent(1, 4, 32'h3000_0000, 32'hF000_0000, 32'hC000_0000, 2'd2, 1, 1);
        expect_ra("R6 R7 skip to idx3", 1, 1, 32'h3000_0ABC, 1, 32'hB000_0ABC);
        write_ent(1, 3, 32'h3000_0000, 32'hF000_0000, 32'hB000_0000, 2'd1, 1, 1);
        expect_ra("R6 R7 skip to idx4", 1, 0, 32'h3000_0ABC, 1, 32'hC000_0ABC);

        // R5: finer mask
        write_ent(1, 5, 32'h5002_0000, 32'hFFFE_0000, 32'h0006_0000, 2'd2, 1, 1);
        expect_ra("R5 fine mask", 1, 1, 32'h5003_ABCD, 1, 32'h0007_ABCD);
        expect_ra("R4 fine mask miss", 1, 1, 32'h5004_ABCD, 0, 32'h0);

        // R11: write and lookup in the same cycle on the selected entry
        @(negedge clk);
        put_write(1, 0, 32'h1000_0000, 32'hF000_0000, 32'hD000_0000, 2'd2, 1, 0);
        lk_valid = 1; lk_data = 1; lk_user = 1; lk_ea = 32'h1111_2222; lk_vsid = 24'h00ABCD;
        @(negedge clk);
        wr_en = 0; lk_valid = 0;
        note_write(1, 0, 32'h1000_0000, 32'hF000_0000, 32'hD000_0000, 2'd2, 1, 0);
        judge("R11 old contents", 1, 32'h8111_2222, 24'h00ABCD, 32'h1111_2222);
        expect_ra("R11 new contents", 1, 1, 32'h1111_2222, 1, 32'hD111_2222);

        // R10: idle cycle gives no response
        @(negedge clk);
        check(rsp_valid == 1'b0, "R10 idle", 64'(rsp_valid), 64'(0));

        // Sweep: random overlapping tables, R4 R5 R6 R7 R9
        for (int round = 0; round < 40; round++) begin
            logic [31:0] pool [4];
            for (int p = 0; p < 4; p++) pool[p] = $urandom;
            for (int b = 0; b < 2; b++) begin
                for (int i = 0; i < 8; i++) begin
                    logic [31:0] msk;
                    msk = 32'hFFFF_FFFF << (17 + $urandom_range(0, 11));
                    write_ent(b[0], i, pool[$urandom_range(0, 3)] & msk, msk, $urandom,
                              2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                              1'($urandom_range(0, 1)));
                end
            end
            for (int k = 0; k < 100; k++) begin
                logic [31:0] ea;
                ea = pool[$urandom_range(0, 3)] ^ ($urandom & 32'h000F_FFFF);
                lookup("R7 sweep", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                       ea, 24'($urandom));
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule